// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 36-bit words between a write clock domain and a read clock domain. The two clocks run freely and may be unrelated or the same clock. The memory depth is a parameter set to 256, 512 or 1024 words. Each pointer crosses into the other domain as a Gray code through a two-stage synchronizer. The full-side flags are computed in the write domain and the empty-side flags in the read domain, so a flag may lag the true state by a few cycles. The lag only ever errs on the safe side.

Two threshold flags warn before the hard limits. Almost-empty compares the number of stored words with one offset, and almost-full compares the number of free memory slots with another. Both offsets are loaded from the write side, either a whole value at a time or one bit at a time through a shift chain; an input picks the loading style. A timing-mode input, captured during master reset, selects one of two modes:

- Standard mode: a read enable pops a word, and the status pins mean full and empty.
- Fall-through mode: the oldest word is presented on the read bus without being asked for, and the status pins mean input-ready and output-ready.

There are two resets. Master reset empties the buffer, restores the default offsets and captures the mode. Partial reset only empties the buffer.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: While a reset is applied, and until the first operation after it, the status pins show the idle state. In standard mode `flag_wr`=0 and `flag_rd`=1. In fall-through mode `flag_wr`=1 and `flag_rd`=0. In both modes `almost_empty`=1 and `almost_full`=0.
- R2: Words leave in the order they were written, with their data unchanged. A write and a read on the same clock edge are both accepted. In standard mode a read accepted at a rising `rd_clk` edge places its word on `rd_data` right after that edge.
- R3: In standard mode `flag_wr` is 1 exactly when DEPTH words are stored. A write presented while the full-side status shows no room is ignored and stores nothing.
- R4: In standard mode `flag_rd` is 1 when no word is stored. A read presented while `flag_rd`=1 is ignored and leaves the stored contents unchanged.
- R5: In fall-through mode the oldest word appears on `rd_data` with `flag_rd`=1 without any read enable. A read enable while `flag_rd`=1 consumes that word. A read enable while `flag_rd`=0 has no effect. `flag_wr`=1 means the memory array has room.
- R6: `almost_empty` is 1 when the number of stored words is at or below the almost-empty offset. In fall-through mode the word waiting on the read bus is included in that count.
- R7: `almost_full` is 1 when the number of free memory-array slots is at or below the almost-full offset.
- R8: With `ofs_serial`=0, a `wr_clk` edge with `ofs_wr`=1 loads `ofs_data` into the almost-full offset when `ofs_sel`=1, and into the almost-empty offset when `ofs_sel`=0.
- R9: With `ofs_serial`=1, each `wr_clk` edge with `ofs_ser_en`=1 shifts `ofs_ser_bit` into a 2×AW-bit chain. After 2×AW shifts, the chain holds the almost-full offset (sent most significant bit first), followed by the almost-empty offset (also sent most significant bit first).
- R10: Partial reset (`prst_n`=0) empties the buffer. It leaves both offsets and the captured timing mode unchanged.
- R11: Master reset (`mrst_n`=0) empties the buffer and sets the offsets to their defaults: almost-empty 8 and almost-full 16. It also captures `fwft_sel` (1 selects fall-through mode).
- R12: Each pointer sent across the clock boundary changes in at most one bit per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled by both clocks |
| prst_n | input | 1 | Partial reset, active low, sampled by both clocks |
| fwft_sel | input | 1 | Timing mode captured during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Word read out |
| flag_wr | output | 1 | Full (standard mode) or input-ready (fall-through mode) |
| flag_rd | output | 1 | Empty (standard mode) or output-ready (fall-through mode) |
| almost_full | output | 1 | Free slots at or below the almost-full offset |
| almost_empty | output | 1 | Stored words at or below the almost-empty offset |
| ofs_serial | input | 1 | Offset loading style: 1 serial, 0 parallel |
| ofs_ser_bit | input | 1 | Serial offset data bit |
| ofs_ser_en | input | 1 | Serial shift enable |
| ofs_wr | input | 1 | Parallel offset load strobe |
| ofs_sel | input | 1 | Parallel target: 1 almost-full, 0 almost-empty |
| ofs_data | input | AW | Parallel offset value |

## Verification
The assertions check on every cycle the properties that hold at each edge:

- pointers do not move while the buffer is blocked;
- the fall-through output stays invalid when there is no data;
- an empty buffer always shows almost-empty;
- a full buffer always shows almost-full;
- each crossing pointer changes in at most one bit.

Only the bench scenarios can show the properties that build up over many cycles. These are the data order against a reference queue, the exact threshold boundaries after each style of offset loading, what each reset keeps and what it clears, and the word presented in fall-through mode before any read request.

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 36,
  parameter int DEF_AE = 8,
  parameter int DEF_AF = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             fwft_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             flag_wr,
  output logic             flag_rd,
  output logic             almost_full,
  output logic             almost_empty,
  input  logic             ofs_serial,
  input  logic             ofs_ser_bit,
  input  logic             ofs_ser_en,
  input  logic             ofs_wr,
  input  logic             ofs_sel,
  input  logic [AW-1:0]    ofs_data
);

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    ae_ofs, af_ofs;

  // write domain
  logic          wrst, mode_w, full_r, af_r, wr_ok;
  logic [AW:0]   wbin, wgray, rq1, rq2;
  logic [AW:0]   wbin_nx, wgray_nx, rq2_bin, wused_nx, wfree_nx;

  // read domain
  logic          rrst, mode_r, empty_r, ovalid, ae_r, fetch, ovalid_nx;
  logic [AW:0]   rbin, rgray, wq1, wq2;
  logic [AW:0]   rbin_nx, rgray_nx, wq2_bin, rused_nx;

  assign wrst     = !mrst_n || !prst_n;
  assign wr_ok    = wr_en && !full_r;
  assign wbin_nx  = wbin + {{AW{1'b0}}, wr_ok};
  assign wgray_nx = b2g(wbin_nx);
  assign rq2_bin  = g2b(rq2);
  assign wused_nx = wbin_nx - rq2_bin;
  assign wfree_nx = (AW+1)'(DEPTH) - wused_nx;

  always_ff @(posedge wr_clk) begin
    if (!mrst_n) mode_w <= fwft_sel;
    if (wrst) begin
      wbin   <= '0;
      wgray  <= '0;
      rq1    <= '0;
      rq2    <= '0;
      full_r <= 1'b0;
      af_r   <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      rq1    <= rgray;
      rq2    <= rq1;
      full_r <= (wgray_nx == {~rq2[AW:AW-1], rq2[AW-2:0]});
      af_r   <= (wfree_nx <= {1'b0, af_ofs});
    end
  end

  always_ff @(posedge wr_clk)
    if (wr_ok && !wrst) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge wr_clk) begin
    if (!mrst_n) begin
      ae_ofs <= AW'(DEF_AE);
      af_ofs <= AW'(DEF_AF);
    end else if (ofs_serial) begin
      if (ofs_ser_en) {af_ofs, ae_ofs} <= {af_ofs[AW-2:0], ae_ofs, ofs_ser_bit};
    end else if (ofs_wr) begin
      if (ofs_sel) af_ofs <= ofs_data;
      else         ae_ofs <= ofs_data;
    end
  end

  assign rrst      = !mrst_n || !prst_n;
  assign fetch     = mode_r ? (!empty_r && (!ovalid || rd_en)) : (rd_en && !empty_r);
  assign rbin_nx   = rbin + {{AW{1'b0}}, fetch};
  assign rgray_nx  = b2g(rbin_nx);
  assign wq2_bin   = g2b(wq2);
  assign ovalid_nx = mode_r && (fetch || (ovalid && !rd_en));
  assign rused_nx  = wq2_bin - rbin_nx + {{AW{1'b0}}, ovalid_nx};

  always_ff @(posedge rd_clk) begin
    if (!mrst_n) mode_r <= fwft_sel;
    if (rrst) begin
      rbin    <= '0;
      rgray   <= '0;
      wq1     <= '0;
      wq2     <= '0;
      empty_r <= 1'b1;
      ovalid  <= 1'b0;
      ae_r    <= 1'b1;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rgray_nx;
      wq1     <= wgray;
      wq2     <= wq1;
      empty_r <= (rgray_nx == wq2);
      ovalid  <= ovalid_nx;
      ae_r    <= (rused_nx <= {1'b0, ae_ofs});
    end
  end

  always_ff @(posedge rd_clk)
    if (fetch && !rrst) rd_data <= mem[rbin[AW-1:0]];

  assign flag_wr      = mode_w ? !full_r : full_r;
  assign flag_rd      = mode_r ? ovalid : empty_r;
  assign almost_full  = af_r;
  assign almost_empty = ae_r;

endmodule

// File: rtl/dual_clock_flag_fifo_chk.sv
module dual_clock_flag_fifo_chk #(
  parameter int AW = 8
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        mrst_n,
  input logic        prst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        full_r,
  input logic        empty_r,
  input logic        ovalid,
  input logic        mode_r,
  input logic        ae_r,
  input logic        af_r,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin,
  input logic [AW:0] wgray,
  input logic [AW:0] rgray
);

  a_r3_full_blocks_write: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
    full_r && wr_en |=> $stable(wbin));

  a_r4_empty_blocks_read: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    !mode_r && empty_r && rd_en |=> $stable(rbin));

  a_r5_no_output_without_data: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    mode_r && empty_r && !ovalid |=> !ovalid);

  a_r6_empty_implies_ae: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    empty_r && !ovalid |-> ae_r);

  a_r7_full_implies_af: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
    full_r |-> af_r);

  a_r12_wgray_one_bit: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r12_rgray_one_bit: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind dual_clock_flag_fifo dual_clock_flag_fifo_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
  .wr_en(wr_en), .rd_en(rd_en), .full_r(full_r), .empty_r(empty_r),
  .ovalid(ovalid), .mode_r(mode_r), .ae_r(ae_r), .af_r(af_r),
  .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray)
);

// File: tb/dual_clock_flag_fifo_tb.sv
module dual_clock_flag_fifo_tb;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic flag_wr, flag_rd, almost_full, almost_empty;
  logic ofs_serial = 1'b0, ofs_ser_bit = 1'b0, ofs_ser_en = 1'b0, ofs_wr = 1'b0, ofs_sel = 1'b0;
  logic [AW-1:0] ofs_data = '0;

  dual_clock_flag_fifo #(.DEPTH(DEPTH)) u_dut (
    .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .flag_wr(flag_wr), .flag_rd(flag_rd), .almost_full(almost_full), .almost_empty(almost_empty),
    .ofs_serial(ofs_serial), .ofs_ser_bit(ofs_ser_bit), .ofs_ser_en(ofs_ser_en),
    .ofs_wr(ofs_wr), .ofs_sel(ofs_sel), .ofs_data(ofs_data)
  );

  int total = 0, bad = 0;
  bit mode = 1'b0;
  int ae_exp = 8, af_exp = 16;
  logic [35:0] q[$];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ae(int n); return n <= ae_exp; endfunction
  function automatic bit exp_af(int n); return (DEPTH - n) <= af_exp; endfunction

  task automatic step(input bit dw, input bit dr);
    logic [35:0] d, er;
    bit aw, ar;
    d  = 36'({$urandom(), $urandom()});
    er = '0;
    aw = dw && (mode ? flag_wr : !flag_wr);
    ar = dr && (mode ? flag_rd : !flag_rd);
    wr_en = dw; wr_data = d; rd_en = dr;
    if (ar) begin
      if (q.size() == 0) chk("R4", "read accepted with empty model", 1, 0);
      else begin
        if (mode) chk("R5", "fall-through head word", rd_data, q[0]);
        er = q.pop_front();
      end
    end
    if (aw) q.push_back(d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (ar && !mode) chk("R2", "standard read data", rd_data, er);
  endtask

  task automatic settle(); repeat (6) @(negedge clk); endtask

  task automatic quiet_check(input string tag);
    int n;
    n = q.size();
    chk("R6", {tag, " almost_empty"}, almost_empty, exp_ae(n));
    if (!mode) begin
      chk("R3", {tag, " full"}, flag_wr, n == DEPTH);
      chk("R4", {tag, " empty"}, flag_rd, n == 0);
      chk("R7", {tag, " almost_full"}, almost_full, exp_af(n));
    end else begin
      chk("R5", {tag, " output ready"}, flag_rd, n > 0);
      chk("R5", {tag, " input ready"}, flag_wr, (n - (n > 0 ? 1 : 0)) < DEPTH);
    end
  endtask

  task automatic wr_n(input int k); for (int i = 0; i < k; i++) step(1, 0); endtask
  task automatic rd_n(input int k); for (int i = 0; i < k; i++) step(0, 1); endtask
  task automatic drain(); while (q.size() > 0) step(0, 1); settle(); endtask

  task automatic do_mrst(input bit m);
    @(negedge clk); mrst_n = 1'b0; fwft_sel = m;
    repeat (3) @(negedge clk);
    mrst_n = 1'b1; mode = m; q.delete(); ae_exp = 8; af_exp = 16;
    @(negedge clk);
  endtask

  task automatic do_prst(input bit sel);
    @(negedge clk); prst_n = 1'b0; fwft_sel = sel;
    repeat (3) @(negedge clk);
    prst_n = 1'b1; q.delete();
    @(negedge clk);
  endtask

  task automatic reset_flags(input string req);
    chk(req, "idle flag_wr", flag_wr, mode);
    chk(req, "idle flag_rd", flag_rd, !mode);
    chk(req, "idle almost_empty", almost_empty, 1);
    chk(req, "idle almost_full", almost_full, 0);
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      int p;
      p = ((i / 400) % 2) ? 75 : 25;
      step(($urandom() % 100) < p, ($urandom() % 100) < (100 - p + 5));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1 / R11 standard mode
    do_mrst(0);
    reset_flags("R1");

    // R6 boundary at default offset 8
    wr_n(9); settle(); quiet_check("R6 nine");
    rd_n(1); settle(); quiet_check("R6 eight");
    drain(); quiet_check("R4 drained");

    // R3 fill, overflow attempts ignored; R7 boundary
    while (q.size() < DEPTH) step(1, 0);
    wr_n(3); settle(); quiet_check("R3 full");
    rd_n(16); settle(); quiet_check("R7 free16");
    rd_n(1); settle(); quiet_check("R7 free17");
    drain();
    rd_n(3); settle(); quiet_check("R4 read when empty");

    // R8 parallel load, R10 partial reset keeps it
    @(negedge clk); ofs_serial = 0; ofs_wr = 1; ofs_sel = 0; ofs_data = 8'd20;
    @(negedge clk); ofs_sel = 1; ofs_data = 8'd30;
    @(negedge clk); ofs_wr = 0; ae_exp = 20; af_exp = 30;
    wr_n(5); do_prst(0); reset_flags("R10");
    wr_n(20); settle(); quiet_check("R8 ae20");
    wr_n(1); settle(); quiet_check("R8 ae21");
    while (q.size() < DEPTH - 31) step(1, 0);
    settle(); quiet_check("R8 free31");
    wr_n(1); settle(); quiet_check("R8 free30");
    drain();

    // R9 serial load: af=5 then ae=3, MSB first each
    @(negedge clk); ofs_serial = 1;
    for (int i = AW - 1; i >= 0; i--) begin ofs_ser_en = 1; ofs_ser_bit = 1'((8'd5 >> i) & 8'd1); @(negedge clk); end
    for (int i = AW - 1; i >= 0; i--) begin ofs_ser_en = 1; ofs_ser_bit = 1'((8'd3 >> i) & 8'd1); @(negedge clk); end
    ofs_ser_en = 0; ofs_serial = 0; ae_exp = 3; af_exp = 5;
    do_prst(0);
    wr_n(3); settle(); quiet_check("R9 ae3");
    wr_n(1); settle(); quiet_check("R9 ae4");
    while (q.size() < DEPTH - 6) step(1, 0);
    settle(); quiet_check("R9 free6");
    wr_n(1); settle(); quiet_check("R9 free5");
    drain();

    // R2 random mixed traffic, standard mode
    rand_run(3000); drain(); quiet_check("R2 std random");

    // R11 master reset restores defaults, captures fall-through mode
    do_mrst(1);
    reset_flags("R11");
    rd_n(3); settle(); quiet_check("R5 read when empty");
    wr_n(1); settle();
    chk("R5", "word shown without read", rd_data, q[0]);
    quiet_check("R5 one word");
    wr_n(7); settle(); quiet_check("R11 ae8");
    wr_n(1); settle(); quiet_check("R11 ae9");

    // R10 partial reset keeps the mode
    do_prst(0);
    reset_flags("R10 mode kept");

    rand_run(3000); drain(); quiet_check("R2 fwft random");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule